// File: doc/BRIEF.md
# Guarded Input Alternative with Cycle Timeout

This block sequences a two-way choice between receiving a value on an input channel and giving up after a fixed number of clock cycles. A one-cycle start pulse activates it. While active it tells the channel partner that it is ready to accept. If the partner offers data before the cycle budget runs out, the block acknowledges the transfer, captures the word and launches the input branch. Otherwise it launches the timeout branch. Each branch start is a single-cycle pulse. The branch bodies live outside the block and return one-cycle done pulses, which the block merges into one registered done output.

The countdown begins with the start pulse and stops as soon as the input guard fires. If data is offered in the same cycle that the budget expires, the input branch wins. Because the merged done is registered, a whole activation always spans at least one clock edge, even when a branch finishes in the cycle it was started.

Top module: `alt_timeout_ctrl`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), accept_o, in_go_o, tmo_go_o, take_o and done_o are all low, and data_o is zero.
- R2: accept_o is high in every cycle where start_i is high or the block is waiting, and low in every other cycle.
- R3: When the block is active (start cycle or waiting) and chan_rdy_i is high, in_go_o and take_o are high in that same cycle. data_o holds chan_data_i from that cycle starting after the next rising edge.
- R4: If chan_rdy_i stays low, tmo_go_o pulses for one cycle exactly TMO_CYC cycles after the start cycle, and accept_o is low in the following cycle.
- R5: If chan_rdy_i is high in the cycle where the budget expires, in_go_o fires and tmo_go_o stays low.
- R6: Each activation produces exactly one branch start pulse. in_go_o and tmo_go_o are never high together, and the block stops waiting after that pulse.
- R7: A start_i pulse while the block is already waiting has no effect. The timeout still fires at the time set by the original start.
- R8: A new activation after a finished one counts the full TMO_CYC cycles again.
- R9: done_o is high in the cycle after in_done_i or tmo_done_i is high, and never in the same cycle as the done input alone.
- R10: chan_rdy_i while the block is idle is ignored: no go pulse, take_o low, and data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle activation pulse |
| chan_rdy_i | input | 1 | Channel partner offers a word |
| chan_data_i | input | DATA_W | Word offered by the partner |
| accept_o | output | 1 | Block is ready to receive |
| take_o | output | 1 | Transfer acknowledged this cycle |
| data_o | output | DATA_W | Last received word |
| in_go_o | output | 1 | Start pulse for the input branch |
| tmo_go_o | output | 1 | Start pulse for the timeout branch |
| in_done_i | input | 1 | Input branch finished |
| tmo_done_i | input | 1 | Timeout branch finished |
| done_o | output | 1 | Registered finish of the whole choice |

## Verification
The embedded assertions check on every cycle that the two branch pulses are mutually exclusive, that a pulse ends the wait, that the timeout never fires while data is offered, and that the counter stays within its budget. They also check that the merged done follows its inputs by one edge. Only the bench scenarios can show the exact expiry cycle, the priority of input over timeout at expiry, that a start while waiting is ignored, that restarts count afresh, and that the captured word is correct. Those scenarios compare against counted cycle positions.

// File: rtl/alt_tmo_pkg.sv
package alt_tmo_pkg;

    typedef struct packed {
        logic in_go;
        logic tmo_go;
    } branch_sel_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_TMO   = 2'b01,
        SEL_INPUT = 2'b10
    } sel_kind_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Input guard wins over the timeout when both are ready.
    function automatic branch_sel_t pick_branch(input logic active,
                                                input logic rdy,
                                                input logic expired);
        branch_sel_t s;
        s.in_go  = active & rdy;
        s.tmo_go = active & expired & ~rdy;
        return s;
    endfunction

    function automatic sel_kind_e kind_of(input branch_sel_t s);
        if (s.in_go)       return SEL_INPUT;
        else if (s.tmo_go) return SEL_TMO;
        else               return SEL_NONE;
    endfunction

endpackage

// File: rtl/alt_cycle_timer.sv
module alt_cycle_timer
    import alt_tmo_pkg::*;
#(
    parameter int unsigned TMO_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic waiting,
    input  logic stop,
    output logic expired
);
    localparam int unsigned CW = cnt_width(TMO_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active || stop) begin
            cnt_q <= '0;
        end else if (waiting) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= CW'(1);
        end
    end

    assign expired = waiting && (cnt_q == LIMIT);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !waiting |-> (cnt_q == '0));

endmodule

// File: rtl/alt_guard_fsm.sv
module alt_guard_fsm
    import alt_tmo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        chan_rdy_i,
    input  logic        expired,
    output logic        active,
    output logic        waiting,
    output branch_sel_t sel
);
    logic wait_q;

    assign active  = start_i | wait_q;
    assign waiting = wait_q;
    assign sel     = pick_branch(active, chan_rdy_i, expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= 1'b0;
        end else begin
            wait_q <= active & ~expired & ~chan_rdy_i;
        end
    end

    // R6
    one_branch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.in_go, sel.tmo_go}));

    // R6
    wait_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (sel.in_go || sel.tmo_go) |=> !wait_q);

    // R5
    no_tmo_on_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        chan_rdy_i |-> !sel.tmo_go);

    // R10
    idle_no_go_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !wait_q) |-> (kind_of(sel) == SEL_NONE));

endmodule

// File: rtl/alt_rx_capture.sv
module alt_rx_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (take) begin
            dout <= din;
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(dout));

endmodule

// File: rtl/alt_done_merge.sv
module alt_done_merge (
    input  logic clk,
    input  logic rst,
    input  logic done_a,
    input  logic done_b,
    output logic done_o
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= done_a | done_b;
    end

    assign done_o = done_q;

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (done_a || done_b) |=> done_o);

endmodule

// File: rtl/alt_timeout_ctrl.sv
module alt_timeout_ctrl
    import alt_tmo_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TMO_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              chan_rdy_i,
    input  logic [DATA_W-1:0] chan_data_i,
    output logic              accept_o,
    output logic              take_o,
    output logic [DATA_W-1:0] data_o,
    output logic              in_go_o,
    output logic              tmo_go_o,
    input  logic              in_done_i,
    input  logic              tmo_done_i,
    output logic              done_o
);
    localparam int unsigned TMO_EFF = (TMO_CYC < 1) ? 1 : TMO_CYC;

    logic        active;
    logic        waiting;
    logic        expired;
    branch_sel_t sel;

    alt_guard_fsm u_guard (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .chan_rdy_i (chan_rdy_i),
        .expired    (expired),
        .active     (active),
        .waiting    (waiting),
        .sel        (sel)
    );

    alt_cycle_timer #(.TMO_CYC(TMO_EFF)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .waiting (waiting),
        .stop    (sel.in_go | expired),
        .expired (expired)
    );

    alt_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .take (sel.in_go),
        .din  (chan_data_i),
        .dout (data_o)
    );

    alt_done_merge u_done (
        .clk    (clk),
        .rst    (rst),
        .done_a (in_done_i),
        .done_b (tmo_done_i),
        .done_o (done_o)
    );

    assign accept_o = active;
    assign take_o   = sel.in_go;
    assign in_go_o  = sel.in_go;
    assign tmo_go_o = sel.tmo_go;

    // R2
    accept_wait_chk: assert property (@(posedge clk) disable iff (rst)
        waiting |-> accept_o);

    // R3
    take_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (chan_rdy_i && accept_o));

endmodule

// File: tb/alt_timeout_ctrl_tb_top.sv
`timescale 1ns/1ps
module alt_timeout_ctrl_tb_top;
    localparam int DW = 8;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst;
    logic start_i, chan_rdy_i, in_done_i, tmo_done_i;
    logic [DW-1:0] chan_data_i;
    logic accept_o, take_o, in_go_o, tmo_go_o, done_o;
    logic [DW-1:0] data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    alt_timeout_ctrl #(.DATA_W(DW), .TMO_CYC(NT)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_rdy_i(chan_rdy_i),
        .chan_data_i(chan_data_i), .accept_o(accept_o), .take_o(take_o),
        .data_o(data_o), .in_go_o(in_go_o), .tmo_go_o(tmo_go_o),
        .in_done_i(in_done_i), .tmo_done_i(tmo_done_i), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // inputs set just after an edge; combinational outputs settle 1ns later
    task automatic drive(input logic s, input logic r, input logic [DW-1:0] d);
        start_i = s; chan_rdy_i = r; chan_data_i = d;
        #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        start_i = 0; chan_rdy_i = 0; in_done_i = 0; tmo_done_i = 0;
    endtask

    task automatic t_reset();
        rst = 1; start_i = 0; chan_rdy_i = 0; chan_data_i = '0;
        in_done_i = 0; tmo_done_i = 0;
        repeat (3) @(posedge clk);
        #1; rst = 0; #1;
        chk("R1 accept", accept_o, 0);
        chk("R1 in_go", in_go_o, 0);
        chk("R1 tmo_go", tmo_go_o, 0);
        chk("R1 take", take_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 data", data_o, 0);
        tick();
    endtask

    // Timeout path: no data; go at start+NT
    task automatic t_timeout(input string tag);
        for (int c = 0; c <= NT; c++) begin
            drive(c == 0, 0, 8'h00);
            chk({tag, " R2 accept"}, accept_o, 1);
            chk({tag, " R4 tmo_go"}, tmo_go_o, (c == NT));
            chk({tag, " R6 in_go"}, in_go_o, 0);
            tick();
        end
        #1;
        chk({tag, " R4 accept after"}, accept_o, 0);
        chk({tag, " R6 no second go"}, tmo_go_o | in_go_o, 0);
    endtask

    task automatic t_input_mid();
        drive(1, 0, 8'h00); tick();
        drive(0, 0, 8'h00); tick();
        drive(0, 1, 8'hA5);
        chk("R3 in_go", in_go_o, 1);
        chk("R3 take", take_o, 1);
        chk("R6 tmo_go low", tmo_go_o, 0);
        tick(); #1;
        chk("R3 data", data_o, 8'hA5);
        chk("R2 accept low", accept_o, 0);
        // R6: nothing more across the old expiry time
        for (int c = 0; c < NT; c++) begin
            chk("R6 quiet", {in_go_o, tmo_go_o}, 0);
            tick(); #1;
        end
    endtask

    task automatic t_input_first_cycle();
        drive(1, 1, 8'h3C);
        chk("R3 immediate go", in_go_o, 1);
        tick(); #1;
        chk("R3 immediate data", data_o, 8'h3C);
        chk("R6 ended", accept_o, 0);
    endtask

    task automatic t_priority();
        for (int c = 0; c < NT; c++) begin
            drive(c == 0, 0, 8'h00); tick();
        end
        drive(0, 1, 8'h5A);
        chk("R5 in_go at expiry", in_go_o, 1);
        chk("R5 tmo_go at expiry", tmo_go_o, 0);
        tick(); #1;
        chk("R5 data", data_o, 8'h5A);
        chk("R5 accept low", accept_o, 0);
    endtask

    task automatic t_restart_ignored();
        for (int c = 0; c <= NT; c++) begin
            drive((c == 0) || (c == 2), 0, 8'h00);
            chk("R7 tmo_go timing", tmo_go_o, (c == NT));
            tick();
        end
        #1;
        chk("R7 no late go", tmo_go_o, 0);
        chk("R7 idle", accept_o, 0);
    endtask

    task automatic t_idle_rdy();
        drive(0, 1, 8'hFF);
        chk("R10 no go", {in_go_o, tmo_go_o}, 0);
        chk("R10 take", take_o, 0);
        chk("R10 accept", accept_o, 0);
        tick(); #1;
        chk("R10 data kept", data_o, 8'h5A);
    endtask

    task automatic t_done();
        in_done_i = 1; #1;
        chk("R9 not same cycle", done_o, 0);
        tick(); #1;
        chk("R9 in_done", done_o, 1);
        tick(); #1;
        chk("R9 drop", done_o, 0);
        tmo_done_i = 1; tick(); #1;
        chk("R9 tmo_done", done_o, 1);
        tick(); #1;
        chk("R9 drop2", done_o, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_timeout("first");
                t_input_mid();
                t_input_first_cycle();
                t_priority();
                t_idle_rdy();
                t_restart_ignored();
                t_timeout("R8 restart");
                t_done();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule